// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a clocked request/ready handshake to a 1M x 4 asynchronous static RAM with active-low chip select, write strobe and output enable. Each accepted request is a single word read or write. The block drives the strobes, the address and the write data in a fixed sequence. Every phase length is a whole number of clock cycles, derived from the clock period and the memory's timing figures, all given as nanosecond parameters. A read returns its word with a one-cycle valid pulse. After reset the block waits out a supply settling interval before it takes any request.

The memory data bus is split at the block boundary into an output word, an output-enable and an input word; the pad-level tristate lives outside. The controller turns on its data drivers only after the memory has had one full cycle with the write strobe low, which is enough to release its pins. It turns them off one cycle after the write strobe rises. Output enable stays high for the whole of a write.

The state machine has six states. PWRUP waits for the settling timer and moves to IDLE. IDLE raises ready, and a request moves it to RD_ACC for a read or to WR_REL for a write. RD_ACC holds the read strobes for the access count and returns to IDLE. WR_REL is one cycle with the write strobe low and the drivers off, followed by WR_DRV. WR_DRV holds the write strobe low with the drivers on for the drive count, followed by WR_HOLD. WR_HOLD is one cycle with the write strobe high and the chip still selected, and it returns to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset release, req_ready stays low and sram_ce_n stays high. req_ready first reads high after the (N_PWR+1)-th rising edge, where N_PWR is the settling time converted to cycles.
- R2: req_ready is high exactly while the sequencer is idle. A request is taken at a rising edge where req_valid and req_ready are both high, and req_ready is low from that edge until the access is over.
- R3: A read holds sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 for N_RD cycles, starting in the cycle after acceptance. N_RD is the largest of the converted read-cycle, address-access, select-access and output-enable-access times.
- R4: After a read, rd_valid is high for exactly one cycle, the cycle right after the access, together with req_ready. rd_data holds the word that was on sram_dq_i in the last access cycle. Writes never raise rd_valid.
- R5: A write keeps sram_oe_n=1 throughout. It holds sram_ce_n=0 and sram_we_n=0 for 1+N_DRV cycles, then one cycle with sram_ce_n=0 and sram_we_n=1, then deselects. N_DRV is the largest of (write-low count minus 1), the data setup count, (write cycle count minus 2) and 1. The write-low count is the largest of the converted write pulse, select-to-end and address-to-end times.
- R6: sram_dq_oe is low in the first write-strobe-low cycle and high in the remaining write-strobe-low cycles and in the single cycle after the strobe rises. It is low at all other times, and never high while sram_oe_n is low.
- R7: While sram_dq_oe is high, sram_dq_o equals the accepted write data. The data is driven and stable for at least the data setup time before sram_we_n rises.
- R8: sram_addr equals the accepted address and does not change while sram_ce_n is low.
- R9: Each nanosecond figure becomes ceil(t / CLK_PERIOD_NS) cycles, with a minimum of one cycle.
- R10: A request presented while req_ready is low, including during the settling wait, has no effect on the pins. It is taken only at the next edge where req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-assert active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request taken this edge |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_o | output | DATA_W | Data toward memory pins |
| sram_dq_oe | output | 1 | Enable for the data pin drivers |
| sram_dq_i | input | DATA_W | Data from memory pins |

## Verification
Each state drives its own pattern on ready and the three strobes, so a wrong state appears at the pins in the very next cycle. A count that is off by one shows as a read or write window one cycle too long or too short, at the state boundary where it ends. A driver turned on too early collides with a memory that is still driving, or breaks the setup window that the memory model measures at the end of the write. A capture in the wrong cycle returns a word that the model has not yet made valid, and this is seen at the rd_valid cycle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_RD_ACC  = 3'd2,
        ST_WR_REL  = 3'd3,
        ST_WR_DRV  = 3'd4,
        ST_WR_HOLD = 3'd5
    } state_e;

    // R9: nanoseconds to whole cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_dwell_counter.sv
`timescale 1ns/1ps
module sram_dwell_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    // cycles spent in the current state, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sram_pwrup_timer.sv
`timescale 1ns/1ps
module sram_pwrup_timer #(
    parameter int WAIT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);

    localparam int TW = $clog2(WAIT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(WAIT_CYC);

    logic [TW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (elapsed != LIMIT) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign done = (elapsed == LIMIT);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] word_q,
    output logic              strobe_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= capture;
            if (capture) begin
                word_q <= pin_data;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_PWRUP_NS    = 1000,
    parameter int T_RC_NS       = 10,
    parameter int T_AA_NS       = 10,
    parameter int T_ACE_NS      = 10,
    parameter int T_DOE_NS      = 5,
    parameter int T_WC_NS       = 10,
    parameter int T_PWE_NS      = 7,
    parameter int T_SCE_NS      = 7,
    parameter int T_AW_NS       = 7,
    parameter int T_SD_NS       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    // R9: every phase length derived from the nanosecond figures
    localparam int N_PWR  = ns_to_cycles(T_PWRUP_NS, CLK_PERIOD_NS);
    localparam int N_RD   = max_int(max_int(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                            ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                    max_int(ns_to_cycles(T_ACE_NS, CLK_PERIOD_NS),
                                            ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS)));
    localparam int N_WLOW = max_int(max_int(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                            ns_to_cycles(T_SCE_NS, CLK_PERIOD_NS)),
                                    ns_to_cycles(T_AW_NS, CLK_PERIOD_NS));
    localparam int N_SD   = ns_to_cycles(T_SD_NS, CLK_PERIOD_NS);
    localparam int N_WC   = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int N_DRV  = max_int(max_int(N_WLOW - 1, N_SD), max_int(N_WC - 2, 1));
    localparam int CNT_W  = $clog2(max_int(N_RD, N_DRV) + 1);

    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(N_DRV - 1);

    state_e             state_q;
    state_e             state_d;
    logic [CNT_W-1:0]   dwell;
    logic               dwell_clr;
    logic               pwr_done;
    logic               accept;
    logic               capture;

    sram_pwrup_timer #(
        .WAIT_CYC (N_PWR)
    ) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_dwell_counter #(
        .CNT_W (CNT_W)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dwell_clr),
        .count (dwell)
    );

    sram_read_capture #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .pin_data (sram_dq_i),
        .word_q   (rd_data),
        .strobe_q (rd_valid)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:   if (pwr_done)          state_d = ST_IDLE;
            ST_IDLE:    if (req_valid)         state_d = req_write ? ST_WR_REL : ST_RD_ACC;
            ST_RD_ACC:  if (dwell == RD_LAST)  state_d = ST_IDLE;
            ST_WR_REL:                         state_d = ST_WR_DRV;
            ST_WR_DRV:  if (dwell == DRV_LAST) state_d = ST_WR_HOLD;
            ST_WR_HOLD:                        state_d = ST_IDLE;
            default:                           state_d = ST_PWRUP;
        endcase
    end

    assign dwell_clr = (state_d != state_q);
    assign capture   = (state_q == ST_RD_ACC) && (state_d == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // registered pin outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_ready  <= 1'b0;
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            sram_addr  <= '0;
            sram_dq_o  <= '0;
        end else begin
            req_ready  <= (state_d == ST_IDLE);
            sram_ce_n  <= !(state_d inside {ST_RD_ACC, ST_WR_REL, ST_WR_DRV, ST_WR_HOLD});
            sram_oe_n  <= (state_d != ST_RD_ACC);
            sram_we_n  <= !(state_d inside {ST_WR_REL, ST_WR_DRV});
            sram_dq_oe <= (state_d inside {ST_WR_DRV, ST_WR_HOLD});
            if (accept) begin
                sram_addr <= req_addr;
                sram_dq_o <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_o
);

    logic seen_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_ready <= 1'b0;
        else if (req_ready) seen_ready <= 1'b1;
    end

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_ready |-> sram_ce_n); // R1

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n)); // R2

    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n)); // R3

    AST_RDVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R5

    AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && !sram_ce_n)); // R6

    AST_DRIVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n))); // R6

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o)); // R7

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R8

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    localparam int P     = 10;
    localparam int TPW   = 1000;
    localparam int TRC   = 25;
    localparam int TAA   = 25;
    localparam int TACE  = 25;
    localparam int TDOE  = 12;
    localparam int TWC   = 25;
    localparam int TPWE  = 18;
    localparam int TSCE  = 18;
    localparam int TAW   = 18;
    localparam int TSD   = 12;

    // R9: expected counts, rounded up with a floor of one cycle
    function automatic int to_cyc(input int ns);
        if (ns <= P) return 1;
        return (ns + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PWR  = to_cyc(TPW);
    localparam int E_RD   = mx(mx(to_cyc(TRC), to_cyc(TAA)), mx(to_cyc(TACE), to_cyc(TDOE)));
    localparam int E_WLOW = mx(mx(to_cyc(TPWE), to_cyc(TSCE)), to_cyc(TAW));
    localparam int E_DRV  = mx(mx(E_WLOW - 1, to_cyc(TSD)), mx(to_cyc(TWC) - 2, 1));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [19:0] sram_addr;
    logic        sram_ce_n;
    logic        sram_we_n;
    logic        sram_oe_n;
    logic [3:0]  sram_dq_o;
    logic        sram_dq_oe;
    logic [3:0]  sram_dq_i;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(20), .DATA_W(4), .CLK_PERIOD_NS(P), .T_PWRUP_NS(TPW),
        .T_RC_NS(TRC), .T_AA_NS(TAA), .T_ACE_NS(TACE), .T_DOE_NS(TDOE),
        .T_WC_NS(TWC), .T_PWE_NS(TPWE), .T_SCE_NS(TSCE), .T_AW_NS(TAW), .T_SD_NS(TSD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [3:0] seed_word(input logic [19:0] a);
        return a[3:0] ^ a[11:8] ^ a[19:16] ^ 4'h5;
    endfunction

    // ---------------- behavioural memory model ----------------
    logic [3:0] mem [logic [19:0]];
    logic [3:0] mem_out = 4'h0;
    logic       mem_drive;
    logic       wr_open = 1'b0;
    realtime    t_acc = 0, t_wfall = 0, t_data = 0, t_addr = 0;

    assign mem_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq_i = mem_drive ? mem_out : 4'h0;

    always @(sram_addr or sram_ce_n or sram_oe_n or sram_we_n) t_acc = $realtime;
    always @(sram_addr) t_addr = $realtime;
    always @(sram_dq_o or posedge sram_dq_oe) t_data = $realtime;

    always @(negedge clk) begin
        if (rst_n && mem_drive) begin
            logic [3:0] w;
            w = mem.exists(sram_addr) ? mem[sram_addr] : seed_word(sram_addr);
            // word valid only once the access time has run out (R3)
            mem_out = (($realtime - t_acc) >= TAA) ? w : ~w;
        end
        if (rst_n) check(!(mem_drive && sram_dq_oe), "R6 bus contention", {31'd0, sram_dq_oe}, 32'd0);
    end

    always @(negedge sram_we_n or negedge sram_ce_n) begin
        if (rst_n && !sram_we_n && !sram_ce_n && !wr_open) begin
            wr_open = 1'b1;
            t_wfall = $realtime;
        end
    end

    always @(posedge sram_we_n or posedge sram_ce_n) begin
        if (wr_open) begin
            wr_open = 1'b0;
            check(($realtime - t_wfall) >= TPWE, "R5 write pulse width",
                  32'($rtoi($realtime - t_wfall)), 32'(TPWE));
            check(sram_dq_oe && (($realtime - t_data) >= TSD), "R7 data setup",
                  32'($rtoi($realtime - t_data)), 32'(TSD));
            check(t_addr <= t_wfall, "R8 address settled before write start",
                  32'($rtoi(t_addr)), 32'($rtoi(t_wfall)));
            mem[sram_addr] = sram_dq_o;
        end
    end

    // ---------------- cycle reference model ----------------
    typedef struct packed {
        logic rdy; logic ce_n; logic oe_n; logic we_n; logic drv; logic rv;
    } pins_t;

    pins_t       exp_q[$];
    pins_t       exp_p = pins_t'(6'b0_1_1_1_0_0);
    int          pwr_edges = 0;
    logic [19:0] exp_addr = '0;
    logic [3:0]  exp_wdata = '0;
    logic [3:0]  exp_rdata = '0;
    logic [3:0]  shadow [logic [19:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            exp_p = pins_t'(6'b0_1_1_1_0_0);
            pwr_edges = 0;
        end else begin
            if (exp_p.rdy && req_valid) begin
                exp_addr = req_addr;
                if (req_write) begin
                    exp_wdata = req_wdata;
                    shadow[req_addr] = req_wdata;
                    exp_q.push_back(pins_t'(6'b0_0_1_0_0_0));
                    for (int i = 0; i < E_DRV; i++) exp_q.push_back(pins_t'(6'b0_0_1_0_1_0));
                    exp_q.push_back(pins_t'(6'b0_0_1_1_1_0));
                end else begin
                    exp_rdata = shadow.exists(req_addr) ? shadow[req_addr] : seed_word(req_addr);
                    for (int i = 0; i < E_RD; i++) exp_q.push_back(pins_t'(6'b0_0_0_1_0_0));
                    exp_q.push_back(pins_t'(6'b1_1_1_1_0_1));
                end
            end
            if (pwr_edges <= E_PWR) pwr_edges++;
            if (exp_q.size() > 0) exp_p = exp_q.pop_front();
            else exp_p = pins_t'({pwr_edges > E_PWR, 5'b1_1_1_0_0});
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(req_ready === exp_p.rdy, (pwr_edges <= E_PWR) ? "R1 ready in settling wait" : "R2 ready",
                  {31'd0, req_ready}, {31'd0, exp_p.rdy});
            check({sram_ce_n, sram_oe_n, sram_we_n} === {exp_p.ce_n, exp_p.oe_n, exp_p.we_n},
                  !exp_p.oe_n ? "R3 R9 read strobes" : (!exp_p.ce_n ? "R5 R9 write strobes" : "R2 idle strobes"),
                  {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, {29'd0, exp_p.ce_n, exp_p.oe_n, exp_p.we_n});
            check(sram_dq_oe === exp_p.drv, "R6 driver enable", {31'd0, sram_dq_oe}, {31'd0, exp_p.drv});
            check(rd_valid === exp_p.rv, "R4 rd_valid", {31'd0, rd_valid}, {31'd0, exp_p.rv});
            if (!exp_p.ce_n)
                check(sram_addr === exp_addr, "R8 address", {12'd0, sram_addr}, {12'd0, exp_addr});
            if (exp_p.drv)
                check(sram_dq_o === exp_wdata, "R7 write data", {28'd0, sram_dq_o}, {28'd0, exp_wdata});
            if (exp_p.rv)
                check(rd_data === exp_rdata, "R4 read data", {28'd0, rd_data}, {28'd0, exp_rdata});
            // R10: a pending request during the settling wait leaves the chip deselected
            if (req_valid && pwr_edges <= E_PWR)
                check(sram_ce_n === 1'b1, "R10 request ignored while not ready", {31'd0, sram_ce_n}, 32'd1);
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [19:0] a, input logic [3:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pause(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b0 && sram_ce_n === 1'b1 && rd_valid === 1'b0 && sram_dq_oe === 1'b0,
              "R1 reset state", {28'd0, req_ready, sram_ce_n, rd_valid, sram_dq_oe}, 32'h4);
        // R10: request held from before reset release through the whole settling wait
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00000; req_wdata = 4'hF;
        rst_n = 1'b1;
        issue(1'b1, 20'h00000, 4'hF);
        issue(1'b0, 20'h00000, 4'h0);
        issue(1'b0, 20'hFFFFF, 4'h0);        // unwritten location
        pause(2);
        issue(1'b1, 20'hFFFFF, 4'h0);
        issue(1'b0, 20'hFFFFF, 4'h0);
        // back-to-back writes, then reads with varying gaps
        for (int i = 0; i < 12; i++) issue(1'b1, {i[3:0], 12'h0, i[3:0]} ^ 20'h5A5A5, i[3:0] ^ 4'h9);
        for (int i = 0; i < 12; i++) begin
            issue(1'b0, {i[3:0], 12'h0, i[3:0]} ^ 20'h5A5A5, 4'h0);
            if (i % 3 == 1) pause(i % 4);
        end
        // overwrite then read back, and a read directly after a write
        issue(1'b1, 20'h00005, 4'h3);
        issue(1'b1, 20'h00005, 4'hC);
        issue(1'b0, 20'h00005, 4'h0);
        issue(1'b1, 20'h80001, 4'hA);
        issue(1'b0, 20'h80001, 4'h0);
        pause(10);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=sequence complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule